// File: doc/BRIEF.md
# BCD Calendar Timekeeping Register File

This block keeps wall-clock time as packed BCD bytes and exposes them, with a status byte and a control byte, through a byte-wide register bus. A free-running base tick is divided down to one-second steps. Each step advances seconds, minutes, hours, date, month, two-digit year and day-of-week, with every carry between fields done in hardware. The date rollover follows the month length and the leap-year rule. The hour byte can hold either 24-hour time or 12-hour time with an afternoon flag.

Software sets the time by first writing the control byte with its write-enable bit set, then writing the time bytes. A read burst is opened by a read with `bus_rd_start` high, which loads the start address. Each further read returns the next address. The first read of a burst copies all time bytes into a shadow, so a step that lands mid-burst never mixes old and new fields. The bus has no back-pressure: every read strobe is accepted and answered by `bus_rvalid` exactly one cycle later, and every write strobe completes in its own cycle. A time write that lands in the same cycle as a one-second step wins, and that step is dropped.

Top module: `bcd_rtc_regfile`

## Requirements
- R1: After reset, addresses 0x00..0x08 read 0x00, 0x00, 0x80, 0x01, 0x01, 0x00, 0x00, 0x00, 0x00 (00:00:00 in 24-hour mode, day 1 of month 1, year 00, weekday 0, status 0, control 0).
- R2: A write to an address in 0x00..0x06 changes the time byte only while bit 6 of the control byte (address 0x08) is 1; otherwise the write leaves the byte unchanged.
- R3: Written time bytes are stored under field masks: seconds 0x7F, minutes 0x7F, hour 0xBF, date 0x3F, month 0x1F, year 0xFF, weekday 0x07.
- R4: Time advances exactly once per TICKS_PER_SEC pulses of `tick_in`, and at no other time. A seconds write (address 0x00) restarts the divider, so the next step comes TICKS_PER_SEC pulses after that write.
- R5: Seconds and minutes count in BCD (0x09 to 0x10, and so on) and wrap 0x59 to 0x00. Each wrap carries into the next field.
- R6: With hour bit 7 = 1 (24-hour mode), the hour counts 0x00..0x23 in BCD in bits 5:0. A wrap from 23 to 00 advances the date.
- R7: With hour bit 7 = 0 (12-hour mode), bit 5 is the PM flag and bits 4:0 run 12, 01..11. The step from 11 to 12 toggles PM. Only 11 PM to 12 AM advances the date.
- R8: The date wraps to 0x01 after 0x31 in months 01, 03, 05, 07, 08, 10 and 12, and after 0x30 in months 04, 06, 09 and 11. In month 02 it wraps after 0x29 when the BCD year is divisible by 4, and after 0x28 otherwise.
- R9: Month wraps 0x12 to 0x01 and carries into the year. The year wraps 0x99 to 0x00.
- R10: Weekday increments 0..6 and wraps 6 to 0 on every date advance.
- R11: `bus_rvalid` is high exactly in the cycle after `bus_rd` and carries `bus_rdata`. Status (0x07) reads 0x00 and ignores writes. Addresses above 0x08 read 0x00.
- R12: The control byte at 0x08 stores all 8 written bits and reads them back.
- R13: A read with `bus_rd_start` uses `bus_addr`, and each later read uses the previous address plus one. Time bytes returned within a burst all come from a copy taken at its first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Base tick pulse, one clock wide |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rd_start | input | 1 | Marks the first read of a burst |
| bus_rdata | output | 8 | Read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |

## Verification
The calendar step is driven from a table of preset times. Each preset sits one second before a different carry chain: a plain BCD digit carry, a minute carry, the 24-hour midnight wrap, the 12-hour noon toggle, 12-hour midnight, 12 PM to 1 PM, 30-day and 31-day month ends, a leap and a common February, and the century wrap. A wrong month length, a wrong leap rule or a wrong PM carry therefore each change a different vector. Directed runs separate gated writes from enabled ones, place ticks just before and just after a divider restart, and put a step between the bytes of a burst.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;
  localparam int REG_W         = 8;
  localparam int TIME_REGS     = 7;
  localparam int IDX_W         = $clog2(TIME_REGS);
  localparam int ADR_SEC       = 0;
  localparam int ADR_STATUS    = 7;
  localparam int ADR_CTRL      = 8;
  localparam int CTRL_WEN_BIT  = 6;
  localparam int HR_MODE24_BIT = 7;
  localparam int HR_PM_BIT     = 5;

  typedef logic [REG_W-1:0] reg_byte_t;
  typedef logic [TIME_REGS-1:0][REG_W-1:0] time_file_t;

  // index 6 .. 0 : weekday, year, month, date, hour, minute, second
  localparam time_file_t TIME_RESET = {8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 8'h00, 8'h00};

  function automatic reg_byte_t field_mask(input int idx);
    case (idx)
      0, 1:    return 8'h7F;
      2:       return 8'hBF;
      3:       return 8'h3F;
      4:       return 8'h1F;
      5:       return 8'hFF;
      default: return 8'h07;
    endcase
  endfunction

  function automatic reg_byte_t bcd_inc(input reg_byte_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*t + u is divisible by 4 exactly when 2*t + u is
  function automatic logic bcd_leap(input reg_byte_t yr);
    logic [5:0] s;
    s = {1'b0, yr[7:4], 1'b0} + {2'b00, yr[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic reg_byte_t month_last_day(input reg_byte_t mon, input reg_byte_t yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic restart,
  output logic sec_pulse
);
  if (TICKS_PER_SEC <= 1) begin : g_direct
    assign sec_pulse = tick_in && !restart;
  end else begin : g_count
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
    logic [CW-1:0] cnt_q;
    logic at_last;

    assign at_last   = (cnt_q == LAST);
    assign sec_pulse = tick_in && at_last && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (tick_in) cnt_q <= at_last ? '0 : cnt_q + CW'(1);
    end

    // R4
    restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !sec_pulse);
  end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_pulse,
  input  logic             wr_stb,
  input  logic [IDX_W-1:0] wr_idx,
  input  reg_byte_t        wr_data,
  output time_file_t       tf
);
  time_file_t adv;
  logic       c_sec, c_min, c_day, c_mon, c_yr;
  logic       hr_day, d_wrap, pm;
  reg_byte_t  hr_cur, hr_val, hr_next, last_day;

  always_comb begin
    adv = tf;
    // seconds and minutes
    c_sec  = tf[0] >= 8'h59;
    adv[0] = c_sec ? 8'h00 : bcd_inc(tf[0]);
    c_min  = c_sec && (tf[1] >= 8'h59);
    if (c_sec) adv[1] = (tf[1] >= 8'h59) ? 8'h00 : bcd_inc(tf[1]);

    // hours, two encodings chosen by the mode bit
    hr_cur = tf[2];
    pm     = hr_cur[HR_PM_BIT];
    hr_day = 1'b0;
    if (hr_cur[HR_MODE24_BIT]) begin
      hr_val  = hr_cur & 8'h3F;
      hr_day  = hr_val >= 8'h23;
      hr_next = hr_day ? 8'h80 : (8'h80 | bcd_inc(hr_val));
    end else begin
      hr_val = hr_cur & 8'h1F;
      if (hr_val >= 8'h12) begin
        hr_next = {2'b00, pm, 5'h01};
      end else if (hr_val == 8'h11) begin
        hr_next = {2'b00, ~pm, 5'h12};
        hr_day  = pm;
      end else begin
        hr_next = {2'b00, pm, 5'h00} | bcd_inc(hr_val);
      end
    end
    if (c_min) adv[2] = hr_next;
    c_day = c_min && hr_day;

    // date and weekday
    last_day = month_last_day(tf[4], tf[5]);
    d_wrap   = tf[3] >= last_day;
    if (c_day) begin
      adv[3] = d_wrap ? 8'h01 : bcd_inc(tf[3]);
      adv[6] = (tf[6] >= 8'h06) ? 8'h00 : tf[6] + 8'h01;
    end
    c_mon = c_day && d_wrap;

    // month and year
    if (c_mon) adv[4] = (tf[4] >= 8'h12) ? 8'h01 : bcd_inc(tf[4]);
    c_yr = c_mon && (tf[4] >= 8'h12);
    if (c_yr) adv[5] = (tf[5] >= 8'h99) ? 8'h00 : bcd_inc(tf[5]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf <= TIME_RESET;
    end else begin
      for (int i = 0; i < TIME_REGS; i++) begin
        if (wr_stb && wr_idx == IDX_W'(i)) tf[i] <= wr_data & field_mask(i);
        else if (sec_pulse && !wr_stb)     tf[i] <= adv[i];
      end
    end
  end

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_pulse && !wr_stb) |=> $stable(tf));
  // R5
  sec_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !wr_stb) |=> (tf[0] != $past(tf[0])));
  // R5
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !wr_stb && tf[0] == 8'h59) |=> (tf[0] == 8'h00 && tf[1] != $past(tf[1])));
  // R10
  weekday_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_pulse && !wr_stb) |=> ($stable(tf[3]) == $stable(tf[6])));
endmodule

// File: rtl/rtc_regbus.sv
`timescale 1ns/1ps
module rtc_regbus
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  reg_byte_t         wr_data,
  input  logic              rd_en,
  input  logic              rd_start,
  input  time_file_t        tf_live,
  output logic              time_wr,
  output logic [IDX_W-1:0]  time_idx,
  output reg_byte_t         time_data,
  output reg_byte_t         rd_data,
  output logic              rd_valid
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_TIMEN = ADDR_W'(TIME_REGS);

  reg_byte_t         ctrl_q;
  logic [ADDR_W-1:0] ptr_q, rd_ptr;
  time_file_t        shadow_q, src;
  reg_byte_t         rd_byte;

  assign time_wr   = wr_en && (addr < A_TIMEN) && ctrl_q[CTRL_WEN_BIT];
  assign time_idx  = addr[IDX_W-1:0];
  assign time_data = wr_data;

  always_comb begin
    rd_ptr  = rd_start ? addr : ptr_q;
    src     = rd_start ? tf_live : shadow_q;
    rd_byte = 8'h00;  // status and unmapped addresses
    for (int i = 0; i < TIME_REGS; i++)
      if (rd_ptr == ADDR_W'(i)) rd_byte = src[i];
    if (rd_ptr == A_CTRL) rd_byte = ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ptr_q    <= '0;
      shadow_q <= TIME_RESET;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (wr_en && addr == A_CTRL) ctrl_q <= wr_data;
      if (rd_en) begin
        rd_data <= rd_byte;
        ptr_q   <= rd_ptr + ADDR_W'(1);
        if (rd_start) shadow_q <= tf_live;
      end
    end
  end

  // R11
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R11
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R13
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_start) |=> $stable(shadow_q));
  // R13
  burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_start) |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));
endmodule

// File: rtl/bcd_rtc_regfile.sv
`timescale 1ns/1ps
module bcd_rtc_regfile
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_rd_start,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid
);
  time_file_t       tf;
  logic             time_wr, sec_pulse, restart;
  logic [IDX_W-1:0] time_idx;
  reg_byte_t        time_data;

  assign restart = time_wr && (time_idx == IDX_W'(ADR_SEC));

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (tick_in),
    .restart   (restart),
    .sec_pulse (sec_pulse)
  );

  rtc_calendar u_calendar (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_pulse (sec_pulse),
    .wr_stb    (time_wr),
    .wr_idx    (time_idx),
    .wr_data   (time_data),
    .tf        (tf)
  );

  rtc_regbus #(.ADDR_W(ADDR_W)) u_regbus (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .wr_en     (bus_wr),
    .wr_data   (bus_wdata),
    .rd_en     (bus_rd),
    .rd_start  (bus_rd_start),
    .tf_live   (tf),
    .time_wr   (time_wr),
    .time_idx  (time_idx),
    .time_data (time_data),
    .rd_data   (bus_rdata),
    .rd_valid  (bus_rvalid)
  );
endmodule

// File: tb/bcd_rtc_regfile_bench.sv
`timescale 1ns/1ps
module bcd_rtc_regfile_bench;
  localparam int TPS = 4;
  localparam int NVEC = 9;
  // preset sec,min,hr,date,mon,yr,wday then expected after one second
  localparam logic [111:0] VECS [NVEC] = '{
    {8'h59,8'h59,8'hA3,8'h28,8'h02,8'h24,8'h03, 8'h00,8'h00,8'h80,8'h29,8'h02,8'h24,8'h04}, // R6 R8 R10 leap
    {8'h59,8'h59,8'hA3,8'h28,8'h02,8'h23,8'h06, 8'h00,8'h00,8'h80,8'h01,8'h03,8'h23,8'h00}, // R8 R10 common
    {8'h59,8'h59,8'hA3,8'h31,8'h12,8'h99,8'h05, 8'h00,8'h00,8'h80,8'h01,8'h01,8'h00,8'h06}, // R9
    {8'h59,8'h59,8'h11,8'h15,8'h06,8'h10,8'h02, 8'h00,8'h00,8'h32,8'h15,8'h06,8'h10,8'h02}, // R7 noon
    {8'h59,8'h59,8'h31,8'h30,8'h04,8'h10,8'h01, 8'h00,8'h00,8'h12,8'h01,8'h05,8'h10,8'h02}, // R7 R8 midnight
    {8'h59,8'h59,8'h32,8'h07,8'h07,8'h10,8'h03, 8'h00,8'h00,8'h21,8'h07,8'h07,8'h10,8'h03}, // R7 12PM->1PM
    {8'h59,8'h59,8'h89,8'h07,8'h07,8'h10,8'h03, 8'h00,8'h00,8'h90,8'h07,8'h07,8'h10,8'h03}, // R5 R6
    {8'h29,8'h14,8'h80,8'h07,8'h07,8'h10,8'h03, 8'h30,8'h14,8'h80,8'h07,8'h07,8'h10,8'h03}, // R5
    {8'h59,8'h59,8'hA3,8'h30,8'h09,8'h00,8'h04, 8'h00,8'h00,8'h80,8'h01,8'h10,8'h00,8'h05}  // R8 30-day
  };

  logic clk = 1'b0, rst_n = 1'b0, tick_in = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_rd_start = 1'b0, bus_rvalid;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  bcd_rtc_regfile #(.TICKS_PER_SEC(TPS)) u_bcd_rtc_regfile (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rd_start(bus_rd_start), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic st, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd_start = st; bus_rd = 1'b1;
    @(posedge clk); #1;
    d = bus_rdata;
    bus_rd = 1'b0; bus_rd_start = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_in = 1'b1;
      @(posedge clk); #1; tick_in = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset contents via one burst, R13 auto-increment
    begin
      logic [7:0] rst_exp [9] = '{8'h00,8'h00,8'h80,8'h01,8'h01,8'h00,8'h00,8'h00,8'h00};
      for (int i = 0; i < 9; i++) begin
        bus_read(8'h00, i == 0, rv);
        chk($sformatf("R1 R13 reset byte %0d", i), rv, rst_exp[i]);
      end
    end
    // R11 latency and unmapped address
    bus_read(8'h20, 1'b1, rv);
    chk("R11 unmapped reads zero", rv, 8'h00);
    chk("R11 rvalid after strobe", {7'd0, bus_rvalid}, 8'h01);
    @(posedge clk); #1;
    chk("R11 rvalid idle", {7'd0, bus_rvalid}, 8'h00);

    // R2 gated write
    bus_write(8'h00, 8'h45);
    bus_read(8'h00, 1'b1, rv);
    chk("R2 write ignored without enable", rv, 8'h00);
    // R12 control readback
    bus_write(8'h08, 8'hC5);
    bus_read(8'h08, 1'b1, rv);
    chk("R12 control readback", rv, 8'hC5);
    bus_write(8'h00, 8'h45);
    bus_read(8'h00, 1'b1, rv);
    chk("R2 write accepted with enable", rv, 8'h45);

    // R3 masks
    bus_write(8'h02, 8'hFF); bus_read(8'h02, 1'b1, rv); chk("R3 hour mask", rv, 8'hBF);
    bus_write(8'h03, 8'hFF); bus_read(8'h03, 1'b1, rv); chk("R3 date mask", rv, 8'h3F);
    bus_write(8'h04, 8'hFF); bus_read(8'h04, 1'b1, rv); chk("R3 month mask", rv, 8'h1F);
    bus_write(8'h06, 8'hFF); bus_read(8'h06, 1'b1, rv); chk("R3 weekday mask", rv, 8'h07);
    bus_write(8'h01, 8'hFF); bus_read(8'h01, 1'b1, rv); chk("R3 minute mask", rv, 8'h7F);

    // R11 status ignores writes
    bus_write(8'h07, 8'hFF);
    bus_read(8'h07, 1'b1, rv);
    chk("R11 status reads zero", rv, 8'h00);

    // table walk: R5 R6 R7 R8 R9 R10
    for (int v = 0; v < NVEC; v++) begin
      for (int i = 0; i < 7; i++) bus_write(8'(i), VECS[v][111-8*i -: 8]);
      ticks(TPS);
      for (int i = 0; i < 7; i++) begin
        bus_read(8'h00, i == 0, rv);
        chk($sformatf("vector %0d byte %0d", v, i), rv, VECS[v][55-8*i -: 8]);
      end
    end

    // R4 divider and restart
    bus_write(8'h00, 8'h10);
    ticks(TPS - 1);
    bus_read(8'h00, 1'b1, rv); chk("R4 no step before full second", rv, 8'h10);
    ticks(1);
    bus_read(8'h00, 1'b1, rv); chk("R4 step on full second", rv, 8'h11);
    ticks(TPS - 2);
    bus_write(8'h00, 8'h20);
    ticks(TPS - 1);
    bus_read(8'h00, 1'b1, rv); chk("R4 restart delays step", rv, 8'h20);
    ticks(1);
    bus_read(8'h00, 1'b1, rv); chk("R4 step after restart", rv, 8'h21);

    // R13 snapshot across a mid-burst step
    bus_write(8'h00, 8'h59);
    bus_write(8'h01, 8'h59);
    bus_write(8'h02, 8'h85);
    ticks(TPS - 1);
    bus_read(8'h00, 1'b1, rv); chk("R13 burst byte 0", rv, 8'h59);
    ticks(1);
    bus_read(8'h00, 1'b0, rv); chk("R13 burst minute kept", rv, 8'h59);
    bus_read(8'h00, 1'b0, rv); chk("R13 burst hour kept", rv, 8'h85);
    bus_read(8'h01, 1'b1, rv); chk("R13 new burst sees step", rv, 8'h00);
    bus_read(8'h00, 1'b0, rv); chk("R6 new burst hour", rv, 8'h86);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule